// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block recovers asynchronous serial characters for one channel. It uses a clock-enable tick that runs at sixteen times the bit rate. The line is resynchronized, and a falling edge seen while idle opens a character. Every bit after that, start and stop included, is settled by a majority vote over three samples taken around the bit centre. A start bit that votes high is dropped as noise, and no character comes out of it.

The frame shape is set by static inputs: five to eight data bits sent least significant bit first, then an optional even or odd parity bit, then a stop bit. At the end of each accepted character the block raises a one-cycle strobe. With it come the data byte and three status flags (parity mismatch, bad stop bit, line break), ready to be written together into a receive queue. A loopback select feeds the channel's own transmit line to the receiver in place of the external input.

Top module: `uart_rx_vote`

## Requirements
- R1: While rst_ni is low and after its release, with the line idle high, valid_o, data_o, parity_err_o, frame_err_o and break_o are all 0.
- R2: len_i chooses the number of data bits as len_i+5 (0→5, 1→6, 2→7, 3→8). The first data bit received lands in data_o[0], and any data_o bits above the chosen length read 0.
- R3: When par_en_i is 1, one parity bit follows the data. par_odd_i=0 asks for an even number of ones over data plus parity, and par_odd_i=1 asks for an odd number. A mismatch sets parity_err_o. When par_en_i is 0, parity_err_o stays 0.
- R4: Each bit is decided by a majority of three line samples taken on ticks 7, 8 and 9 of its sixteen-tick period, counted from the tick that detected the start edge. A disturbance that reaches only one of the three samples does not change the bit.
- R5: A low level that has ended before the start bit's samples is a false start. It produces no valid_o pulse, and reception stays correct afterwards.
- R6: frame_err_o is set with the character when the stop bit votes 0.
- R7: break_o is set, together with frame_err_o and data_o = 0, when every data bit, the parity bit (if enabled) and the stop bit vote 0. After a break no new character starts until the line has returned high.
- R8: When loop_en_i is 1, the receiver takes loop_tx_i and ignores rx_i.
- R9: Every complete frame gives exactly one valid_o pulse, one clock cycle long, with the data and flags valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 per bit |
| rx_i | input | 1 | External serial input, idle high |
| loop_en_i | input | 1 | Selects loop_tx_i as receiver input |
| loop_tx_i | input | 1 | Local transmit line for loopback |
| len_i | input | 2 | Data length code (bits = code + 5) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| data_o | output | 8 | Received character |
| parity_err_o | output | 1 | Parity mismatch flag |
| frame_err_o | output | 1 | Stop bit voted 0 |
| break_o | output | 1 | Whole frame voted 0 |
| valid_o | output | 1 | One-cycle character strobe |

## Verification
The bench builds the block with its defaults: a sixteen-tick bit, three votes and a two-stage synchronizer. The tick fires every fourth clock, so each sample is four clocks from the next. With that spacing, a four-clock glitch placed at a bit centre is certain to reach exactly one of the three votes, whatever the phase of the start-edge detection. That makes the single-sample rejection of R4 directly observable. Short start pulses, forced stop bits, wrong parity, an all-zero frame held low past its end, and loopback with rx_i tied low cover the remaining paths.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
  } rx_cfg_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic loop_en_i,
  input  logic loop_tx_i,
  output logic rx_s_o
);
  logic [STAGES-1:0] sync_q;
  logic              src;

  assign src = loop_en_i ? loop_tx_i : rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], src};
  end

  assign rx_s_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int OS_RATE = 16,
  parameter int N_SAMP  = 3,
  localparam int PW     = $clog2(OS_RATE),
  localparam int FIRST  = OS_RATE/2 - N_SAMP/2,
  localparam int LAST   = FIRST + N_SAMP - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          active_i,
  input  logic [PW-1:0] phase_i,
  input  logic          rx_s_i,
  output logic          done_o,
  output logic          bit_o
);
  localparam int SW = N_SAMP - 1;
  logic [SW-1:0] sh_q;
  logic          in_win;

  assign in_win = active_i && tick_i &&
                  (phase_i >= PW'(FIRST)) && (phase_i < PW'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (in_win) sh_q <= {sh_q[SW-2:0], rx_s_i};
  end

  assign done_o = active_i && tick_i && (phase_i == PW'(LAST));
  assign bit_o  = $countones({sh_q, rx_s_i}) > (N_SAMP/2);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE  = 16,
  parameter int DATA_MAX = 8,
  localparam int PW      = $clog2(OS_RATE),
  localparam int IW      = $clog2(DATA_MAX)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_s_i,
  input  rx_cfg_t             cfg_i,
  input  logic                vdone_i,
  input  logic                vbit_i,
  output logic                active_o,
  output logic [PW-1:0]       phase_o,
  output logic [DATA_MAX-1:0] data_o,
  output logic                parity_err_o,
  output logic                frame_err_o,
  output logic                break_o,
  output logic                valid_o
);
  rx_state_e             state_q;
  rx_cfg_t               cfg_q;
  logic [PW-1:0]         phase_q;
  logic [IW-1:0]         idx_q;
  logic [DATA_MAX-1:0]   data_q;
  logic                  par_q, perr_q, any1_q;
  logic [IW:0]           nbits;

  assign nbits    = (IW+1)'(cfg_q.len) + (IW+1)'(5);
  assign active_o = (state_q != ST_IDLE) && (state_q != ST_BRK);
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cfg_q        <= '0;
      phase_q      <= '0;
      idx_q        <= '0;
      data_q       <= '0;
      par_q        <= 1'b0;
      perr_q       <= 1'b0;
      any1_q       <= 1'b0;
      data_o       <= '0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
      break_o      <= 1'b0;
      valid_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (active_o && tick_i)
        phase_q <= (phase_q == PW'(OS_RATE-1)) ? '0 : phase_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (tick_i && !rx_s_i) begin
          state_q <= ST_START;
          phase_q <= '0;
          cfg_q   <= cfg_i;
        end
        ST_START: if (vdone_i) begin
          if (vbit_i) state_q <= ST_IDLE;  // false start
          else begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            perr_q  <= 1'b0;
            any1_q  <= 1'b0;
          end
        end
        ST_DATA: if (vdone_i) begin
          data_q[idx_q] <= vbit_i;
          par_q         <= par_q ^ vbit_i;
          any1_q        <= any1_q | vbit_i;
          idx_q         <= idx_q + 1'b1;
          if ({1'b0, idx_q} == nbits - 1'b1)
            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (vdone_i) begin
          perr_q  <= par_q ^ vbit_i ^ cfg_q.par_odd;
          any1_q  <= any1_q | vbit_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (vdone_i) begin
          valid_o      <= 1'b1;
          data_o       <= data_q;
          parity_err_o <= cfg_q.par_en & perr_q;
          frame_err_o  <= !vbit_i;
          break_o      <= !vbit_i && !any1_q;
          state_q      <= (!vbit_i && !any1_q) ? ST_BRK : ST_IDLE;
        end
        ST_BRK: if (rx_s_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r7_break_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && break_o |-> frame_err_o && data_o == '0);
  a_r7_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BRK && !rx_s_i |=> state_q == ST_BRK);
  a_r5_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_START && vdone_i && vbit_i |=> state_q == ST_IDLE && !valid_o);
  a_r3_no_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !cfg_q.par_en |-> !parity_err_o);
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int N_SAMP      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_MAX    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       loop_en_i,
  input  logic       loop_tx_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic [7:0] data_o,
  output logic       parity_err_o,
  output logic       frame_err_o,
  output logic       break_o,
  output logic       valid_o
);
  localparam int PW = $clog2(OS_RATE);

  logic          rx_s, vdone, vbit, active;
  logic [PW-1:0] phase;
  rx_cfg_t       cfg;

  assign cfg = '{len: len_i, par_en: par_en_i, par_odd: par_odd_i};

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i, .loop_en_i, .loop_tx_i, .rx_s_o(rx_s)
  );

  rx_vote #(.OS_RATE(OS_RATE), .N_SAMP(N_SAMP)) u_vote (
    .clk_i, .rst_ni, .tick_i, .active_i(active), .phase_i(phase),
    .rx_s_i(rx_s), .done_o(vdone), .bit_o(vbit)
  );

  rx_frame #(.OS_RATE(OS_RATE), .DATA_MAX(DATA_MAX)) u_frame (
    .clk_i, .rst_ni, .tick_i, .rx_s_i(rx_s), .cfg_i(cfg),
    .vdone_i(vdone), .vbit_i(vbit), .active_o(active), .phase_o(phase),
    .data_o, .parity_err_o, .frame_err_o, .break_o, .valid_o
  );
endmodule

// File: tb/tb_uart_rx_vote.sv
module tb_uart_rx_vote;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic rx_i = 1'b1, loop_en_i = 1'b0, loop_tx_i = 1'b1;
  logic [1:0] len_i = 2'd3;
  logic par_en_i = 1'b0, par_odd_i = 1'b0;
  logic [7:0] data_o;
  logic parity_err_o, frame_err_o, break_o, valid_o;

  int n_run = 0, n_fail = 0;
  int got_n;
  logic [7:0] got_d;
  logic got_pe, got_fe, got_bk;
  logic [1:0] tcnt = '0;

  uart_rx_vote dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tcnt   <= tcnt + 2'd1;
    tick_i <= (tcnt == 2'd3);
  end

  // fields: len[13:12] pen[11] podd[10] data[9:2] badpar[1] stop[0]
  localparam logic [13:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b0, 8'h2D, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b0, 8'h81, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit lvl, input bit tgt);
    if (tgt) loop_tx_i = lvl; else rx_i = lvl;
  endtask

  task automatic cap_clk();
    @(negedge clk_i);
    if (valid_o) begin
      got_n++;
      got_d = data_o; got_pe = parity_err_o;
      got_fe = frame_err_o; got_bk = break_o;
    end
  endtask

  task automatic idle(input bit lvl, input bit tgt, input int clks);
    for (int i = 0; i < clks; i++) begin
      drive(lvl, tgt);
      cap_clk();
    end
  endtask

  // glitch_bit: frame bit index (0 = start) to disturb at its centre, -1 none
  task automatic send(input logic [13:0] v, input bit tgt, input int glitch_bit,
                      input bit idle_lvl);
    logic [1:0] ln; logic pen, podd, bp, sv; logic [7:0] d;
    int nb, nf; logic [11:0] fr;
    {ln, pen, podd, d, bp, sv} = v;
    nb = int'(ln) + 5;
    fr = '0;
    fr[0] = 1'b0;
    for (int i = 0; i < nb; i++) fr[1+i] = d[i];
    nf = 1 + nb;
    if (pen) begin
      fr[nf] = (^(d & 8'((1 << nb) - 1))) ^ podd ^ bp;
      nf++;
    end
    fr[nf] = sv;
    nf++;
    len_i = ln; par_en_i = pen; par_odd_i = podd;
    got_n = 0;
    for (int b = 0; b < nf; b++)
      for (int c = 0; c < BITC; c++) begin
        drive((b == glitch_bit && c >= 30 && c < 34) ? ~fr[b] : fr[b], tgt);
        cap_clk();
      end
    idle(idle_lvl, tgt, 3 * BITC);
  endtask

  task automatic expect_char(input logic [13:0] v, input string req);
    logic [7:0] m; int nb; logic brk;
    nb  = int'(v[13:12]) + 5;
    m   = v[9:2] & 8'((1 << nb) - 1);
    brk = !v[0] && m == 0 && !(v[11] && (v[10] ^ v[1]));
    chk(got_n == 1, req, "valid count", got_n, 1);
    chk(got_d == m, req, "data", got_d, m);
    chk(got_pe == (v[11] & v[1]), req, "parity_err", got_pe, v[11] & v[1]);
    chk(got_fe == !v[0], req, "frame_err", got_fe, !v[0]);
    chk(got_bk == brk, req, "break", got_bk, brk);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    chk(valid_o == 0 && data_o == 0 && {parity_err_o, frame_err_o, break_o} == 0,
        "R1", "outputs in reset", {data_o, valid_o}, 0);
    rst_ni = 1'b1;
    got_n = 0;
    idle(1'b1, 1'b0, 2 * BITC);
    chk(got_n == 0 && data_o == 0, "R1", "idle after reset", got_n, 0);

    // table walk: R2 R3 R6 R7 R9
    foreach (VEC[k]) begin
      send(VEC[k], 1'b0, -1, 1'b1);
      expect_char(VEC[k], k == 7 ? "R7" : (k < 2 ? "R2" : (k == 5 ? "R6" : "R3")));
    end

    // R4: one-sample glitches on data bit and start bit
    send({2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1}, 1'b0, 3, 1'b1);
    expect_char({2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1}, "R4");
    send({2'd3, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b1}, 1'b0, 0, 1'b1);
    expect_char({2'd3, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b1}, "R4");

    // R5: short low pulse, then a good character
    got_n = 0;
    idle(1'b0, 1'b0, 3 * TDIV);
    idle(1'b1, 1'b0, 3 * BITC);
    chk(got_n == 0, "R5", "false start strobes", got_n, 0);
    send({2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1}, 1'b0, -1, 1'b1);
    expect_char({2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1}, "R5");

    // R7: break held low, no new character until line high
    send({2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, 1'b0, -1, 1'b0);
    expect_char({2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, "R7");
    got_n = 0;
    idle(1'b0, 1'b0, 12 * BITC);
    chk(got_n == 0, "R7", "strobes while held low", got_n, 0);
    idle(1'b1, 1'b0, 2 * BITC);
    send({2'd1, 1'b0, 1'b0, 8'h21, 1'b0, 1'b1}, 1'b0, -1, 1'b1);
    expect_char({2'd1, 1'b0, 1'b0, 8'h21, 1'b0, 1'b1}, "R7");

    // R8: loopback path, rx_i held low
    loop_en_i = 1'b1;
    rx_i = 1'b0;
    idle(1'b1, 1'b1, 2 * BITC);
    send({2'd3, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b1}, 1'b1, -1, 1'b1);
    expect_char({2'd3, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b1}, "R8");
    got_n = 0;
    for (int i = 0; i < 12 * BITC; i++) begin
      rx_i = (i / BITC) % 2 == 1;
      cap_clk();
    end
    chk(got_n == 0, "R8", "rx_i ignored in loopback", got_n, 0);
    loop_en_i = 1'b0;
    rx_i = 1'b1;
    idle(1'b1, 1'b0, 2 * BITC);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule